// File: doc/BRIEF.md
# Scanline display timing generator

This block paces a 256x192 display in system clocks. A sub-dot divider, a dot counter and a line counter run freely from reset. Together they produce the horizontal blank and vertical blank status flags, a line count that software can read, and two single-cycle strobes. One strobe marks the first cycle of every visible line, when a pixel fetcher starts work on that line. The other marks the first cycle of the first blanking line, when a double-buffered frame store swaps its halves.

A programmable line-compare register is loaded through a one-cycle write strobe. The coincidence status bit is re-evaluated only when the line counter advances, and shows whether the newly entered line equals the compare value. Because of this, a write to the compare register never changes the status bit in the middle of a line.

All timing figures are parameters. By default a dot lasts 6 clocks, a line is 256 drawn dots followed by 99 blank dots, and a frame is 263 lines, of which the first 192 are drawn.

Top module: `scan_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `line_cnt` is 0 and `hblank`, `vblank`, `coinc` and `frame_swap` are 0.
- R2: Each line lasts (DRAW_DOTS+BLANK_DOTS)*CLKS_PER_DOT cycles. `hblank` is 0 for the first DRAW_DOTS*CLKS_PER_DOT cycles of the line and 1 for the rest.
- R3: `line_cnt` advances by one on the clock edge that ends a line, and wraps from TOTAL_LINES-1 to 0.
- R4: `vblank` is 1 exactly while `line_cnt` is in the range VIS_LINES to TOTAL_LINES-2, and is 0 on line TOTAL_LINES-1.
- R5: On the edge where the line advances, `coinc` takes the value (new line number == compare register). At all other edges it holds its value, so line 0 after reset reads 0 even when the compare value is 0.
- R6: When `cmp_wr` is high at a clock edge, the compare register loads `cmp_data` (9 bits). A line advance on that same edge still uses the old compare value.
- R7: `draw_start` is high for exactly the first cycle of each line whose number is below VIS_LINES, and is low at all other times.
- R8: `frame_swap` is high for exactly the first cycle of line VIS_LINES, and is low at all other times.
- R9: With default parameters, `hblank` rises 1536 cycles into line 0, and line 1 begins 2130 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_wr | input | 1 | Load strobe for the compare register |
| cmp_data | input | LINE_W | Value loaded into the compare register |
| line_cnt | output | LINE_W | Current line number |
| hblank | output | 1 | Horizontal blank status |
| vblank | output | 1 | Vertical blank status |
| coinc | output | 1 | Line equals compare value, set at the last line advance |
| draw_start | output | 1 | First cycle of a visible line |
| frame_swap | output | 1 | First cycle of the first blanking line |

## Verification
Every counter output and status flag is registered and changes on the edge that ends a dot, the draw portion or the line. The value that belongs to cycle t after reset release can therefore be read half a cycle after edge t. The two strobes are decoded from the registered counters, so they are valid in that same cycle. The bench counts edges from the release of reset, derives the expected line, the dot phase and the flags arithmetically from that count, and samples every output on the falling edge. A compare write that is applied before edge t is entered into the bench's model only after that edge's coincidence update, which matches the one-edge latency of the compare register.

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int CLKS_PER_DOT = 6,
  parameter int DRAW_DOTS    = 256,
  parameter int BLANK_DOTS   = 99,
  parameter int VIS_LINES    = 192,
  parameter int TOTAL_LINES  = 263,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_wr,
  input  logic [LINE_W-1:0] cmp_data,
  output logic [LINE_W-1:0] line_cnt,
  output logic              hblank,
  output logic              vblank,
  output logic              coinc,
  output logic              draw_start,
  output logic              frame_swap
);
  localparam int LINE_DOTS = DRAW_DOTS + BLANK_DOTS;
  localparam int SUB_W = (CLKS_PER_DOT > 1) ? $clog2(CLKS_PER_DOT) : 1;
  localparam int DOT_W = $clog2(LINE_DOTS);

  logic [SUB_W-1:0]  sub;
  logic [DOT_W-1:0]  dot;
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] cmp_q;
  logic [LINE_W-1:0] next_line;
  logic dot_end, draw_end, line_end, line_first;

  assign dot_end    = (sub == SUB_W'(CLKS_PER_DOT - 1));
  assign draw_end   = dot_end && (dot == DOT_W'(DRAW_DOTS - 1));
  assign line_end   = dot_end && (dot == DOT_W'(LINE_DOTS - 1));
  assign next_line  = (line == LINE_W'(TOTAL_LINES - 1)) ? '0 : line + 1'b1;
  assign line_first = (sub == '0) && (dot == '0);

  assign line_cnt   = line;
  assign draw_start = line_first && (line < LINE_W'(VIS_LINES));
  assign frame_swap = line_first && (line == LINE_W'(VIS_LINES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
      dot <= '0;
    end else begin
      sub <= dot_end ? '0 : sub + 1'b1;
      if (dot_end) dot <= line_end ? '0 : dot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line   <= '0;
      hblank <= 1'b0;
      vblank <= 1'b0;
      coinc  <= 1'b0;
    end else begin
      if (draw_end) hblank <= 1'b1;
      else if (line_end) hblank <= 1'b0;
      if (line_end) begin
        line  <= next_line;
        coinc <= (next_line == cmp_q);
        if (next_line == LINE_W'(VIS_LINES)) vblank <= 1'b1;
        else if (next_line == LINE_W'(TOTAL_LINES - 1)) vblank <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_data;
  end

  // R2
  hblank_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hblank == (dot >= DOT_W'(DRAW_DOTS)));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line_cnt));

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt < LINE_W'(TOTAL_LINES));

  // R4
  vblank_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank == ((line_cnt >= LINE_W'(VIS_LINES)) && (line_cnt < LINE_W'(TOTAL_LINES - 1))));

  // R5
  coinc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(coinc));

  // R7
  draw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draw_start |-> (!hblank && !vblank));

  // R8
  swap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_swap |-> (vblank && !hblank && !draw_start));

  // R8
  swap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_swap |=> !frame_swap);
endmodule

// File: tb/sim_scan_timer.sv
`timescale 1ns/1ps
module sim_scan_timer;
  localparam int C = 2, DR = 8, BL = 3, VL = 6, TL = 9;
  localparam int LL = C * (DR + BL);
  localparam int NCYC = 7000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_wr = 1'b0;
  logic [8:0] cmp_data = '0;
  logic [8:0] line_cnt, d_line;
  logic hblank, vblank, coinc, draw_start, frame_swap;
  logic d_hb, d_vb, d_co, d_ds, d_fs;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scan_timer #(.CLKS_PER_DOT(C), .DRAW_DOTS(DR), .BLANK_DOTS(BL),
               .VIS_LINES(VL), .TOTAL_LINES(TL), .LINE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
    .line_cnt(line_cnt), .hblank(hblank), .vblank(vblank), .coinc(coinc),
    .draw_start(draw_start), .frame_swap(frame_swap));

  scan_timer u1 (
    .clk(clk), .rst_n(rst_n), .cmp_wr(1'b0), .cmp_data(9'd0),
    .line_cnt(d_line), .hblank(d_hb), .vblank(d_vb), .coinc(d_co),
    .draw_start(d_ds), .frame_swap(d_fs));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    int t, mcmp, ecoinc, ln, pos;
    bit wr;
    int wdata;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "line in reset", line_cnt, 0);
    chk("R1", "hblank in reset", hblank, 0);
    chk("R1", "vblank in reset", vblank, 0);
    chk("R1", "coinc in reset", coinc, 0);
    chk("R1", "frame_swap in reset", frame_swap, 0);
    rst_n = 1'b1;
    t = 0; mcmp = 0; ecoinc = 0;
    while (t < NCYC) begin
      ln  = (t / LL) % TL;
      pos = t % LL;
      if (t == 0) begin
        chk("R1", "line after release", line_cnt, 0);
        chk("R1", "coinc after release", coinc, 0);
        chk("R1", "hblank after release", hblank, 0);
      end
      chk("R3", "line_cnt", line_cnt, ln);
      chk("R2", "hblank", hblank, (pos / C) >= DR);
      chk("R4", "vblank", vblank, (ln >= VL) && (ln < TL - 1));
      chk("R5", "coinc", coinc, ecoinc);
      chk("R7", "draw_start", draw_start, (pos == 0) && (ln < VL));
      chk("R8", "frame_swap", frame_swap, (pos == 0) && (ln == VL));
      if (t == 0 || t == 1535 || t == 1536 || t == 2129 || t == 2130) begin
        chk("R9", "default line", d_line, (t >= 2130) ? 1 : 0);
        chk("R9", "default hblank", d_hb, (t == 1536 || t == 2129) ? 1 : 0);
        chk("R9", "default draw_start", d_ds, (t == 0 || t == 2130) ? 1 : 0);
      end
      wr = (t % 37 == 5) || (t % 53 == 21);
      wdata = (t / 37) % (TL + 2);
      cmp_wr = wr;
      cmp_data = 9'(wdata);
      @(posedge clk);
      t++;
      if (t % LL == 0) ecoinc = (((t / LL) % TL) == mcmp) ? 1 : 0; // R6 old value used
      if (wr) mcmp = wdata;                                        // R6 load
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #((NCYC + 1000) * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule